// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block derives a clock for an output pin from a 32 MHz reference. A 3-bit rate code selects the output frequency, or turns the output off. A separate configuration strobe sets a shadow-select bit. That bit decides when a later rate write takes effect. With the bit clear, the new code is adopted at the next safe switching point. With the bit set, the code waits until the device has been through a sleep cycle.

The block also takes part in entering sleep. When sleep is requested while the transceiver is in its off state, the block stops the output cleanly and then raises a one-cycle sleep-entry-allowed strobe. At the faster rates it first delivers a fixed number of extra clock cycles, so that a downstream consumer clocked by this output can finish its work. Sleep ends when the request is withdrawn. Any staged rate code is then adopted and the output restarts from low.

Top module: `clkout_gen`

## Requirements
- R1: While reset is asserted, `clkOut` and `sleepOk` are 0. After reset the active code is 1, so both levels last 16 reference cycles, and the shadow-select bit is 1.
- R2: Each level of `clkOut` lasts a fixed number of reference cycles set by the active code: 16, 8, 4, 2 and 1 for codes 1 to 5 (1, 2, 4, 8, 16 MHz), 64 for code 6 (250 kHz) and 256 for code 7 (62.5 kHz).
- R3: With active code 0, `clkOut` stays at 0.
- R4: A rate write made while the shadow-select bit is 0 becomes active at the end of the next low level of `clkOut`, and the next high level uses the new code.
- R5: No level of `clkOut` is shorter than the level length of the code that was active when that level began.
- R6: A rate write made while the shadow-select bit is 1 leaves the output rate unchanged while running. It becomes active when the device wakes from the next sleep.
- R7: With `trxOff`=1 and an active code from 1 to 5, a high `sleepReq` lets exactly 35 more rising edges appear on `clkOut`. `sleepOk` then pulses for one cycle, in the cycle in which `clkOut` has just returned low.
- R8: With `trxOff`=1 and an active code of 0, 6 or 7, a high `sleepReq` stops `clkOut` at its next low level with no further rising edge, and `sleepOk` pulses for one cycle.
- R9: After `sleepOk`, `clkOut` stays at 0 until `sleepReq` falls. It then restarts after a complete low level.
- R10: `sleepReq` has no effect while `trxOff` is 0: no `sleepOk` pulse appears and the clock keeps running.
- R11: A rate write made during the extra-cycle countdown does not alter the countdown. It takes effect only on wake.
- R12: `cfgWrEn` loads `cfgShadow` into the shadow-select bit. A rate write in the same cycle obeys the newly written bit. A later write replaces a staged code that has not yet been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Strobe that loads the shadow-select bit |
| cfgShadow | input | 1 | Shadow-select value: 1 defers rate writes until after sleep |
| rateWrEn | input | 1 | Strobe that writes a rate code |
| rateCode | input | 3 | Rate code: 0 off, 1..5 = 1..16 MHz, 6 = 250 kHz, 7 = 62.5 kHz |
| trxOff | input | 1 | High while the transceiver is in its off state |
| sleepReq | input | 1 | Sleep request; a falling edge while asleep wakes the block |
| clkOut | output | 1 | Divided output clock |
| sleepOk | output | 1 | One-cycle strobe: sleep may now be entered |

## Verification
A wrong level counter shows within one level length as a high or low phase of the wrong width. That is at most 256 reference cycles at the slowest rate. A wrong staged-code flag or mode register shows at the next low-to-high boundary or at the next wake, as a rate that changes too early or too late. An off-by-one in the extra-cycle counter only shows at the end of a sleep sequence, as a 34th or 36th rising edge or a misplaced `sleepOk`. For that reason the bench compares both outputs against a reference model on every cycle, and also counts the rising edges between the request and the strobe.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_HALF = 256;
  localparam int CNT_W    = $clog2(MAX_HALF);
  localparam int FAST_LO  = 1;
  localparam int FAST_HI  = 5;
  localparam int SLOW_A_HALF = 64;
  localparam int SLOW_B_HALF = 256;

  typedef enum logic [1:0] {MODE_RUN, MODE_EXTEND, MODE_SLEEP} modeE;

  // Strobes from control to datapath
  typedef struct packed {
    logic              holdLow;  // keep output low at the low/high boundary
    logic [CODE_W-1:0] rate;     // code to use for the next level
  } dpCtlS;

  // Reload value (level length minus one) for a code
  function automatic logic [CNT_W-1:0] reloadOf(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd0:    r = '0;
      3'd6:    r = CNT_W'(SLOW_A_HALF - 1);
      3'd7:    r = CNT_W'(SLOW_B_HALF - 1);
      default: r = CNT_W'((1 << (FAST_HI - int'(code))) - 1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkout_dp.sv
module clkout_dp
  import clkout_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  dpCtlS ctl,
  output logic  clkLevel,
  output logic  atLow,
  output logic  atFall
);
  logic [CNT_W-1:0] halfCnt;
  logic             rise;

  assign atLow  = !clkLevel && (halfCnt == '0);
  assign atFall =  clkLevel && (halfCnt == '0);
  assign rise   = atLow && !ctl.holdLow && (ctl.rate != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkLevel <= 1'b0;
      halfCnt  <= '0;
    end else if (atFall) begin
      clkLevel <= 1'b0;
      halfCnt  <= reloadOf(ctl.rate);
    end else if (rise) begin
      clkLevel <= 1'b1;
      halfCnt  <= reloadOf(ctl.rate);
    end else if (halfCnt != '0) begin
      halfCnt  <= halfCnt - 1'b1;
    end
  end

  // R9: a held-low request never produces a rising edge
  assert_hold_no_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    (atLow && ctl.holdLow) |=> !clkLevel);
  // R3: code 0 at the boundary keeps the output low
  assert_off_no_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (atLow && ctl.rate == '0) |=> !clkLevel);
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int EXTRA_RISES = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgShadow,
  input  logic              rateWrEn,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              trxOff,
  input  logic              sleepReq,
  input  logic              atLow,
  input  logic              atFall,
  input  logic              clkLevel,
  output dpCtlS             ctl,
  output logic              sleepOk
);
  localparam int EXT_W = $clog2(EXTRA_RISES + 1);

  modeE              mode;
  logic [CODE_W-1:0] activeRate, stagedRate;
  logic              stagedValid, stagedImm, shadowSel;
  logic [EXT_W-1:0]  extCnt;
  logic              isFast, sleepHit, applyImm, wake, effShadow;

  assign isFast    = (activeRate >= CODE_W'(FAST_LO)) && (activeRate <= CODE_W'(FAST_HI));
  assign sleepHit  = (mode == MODE_RUN) && atLow && sleepReq && trxOff;
  assign applyImm  = (mode == MODE_RUN) && atLow && !sleepHit && stagedValid && stagedImm;
  assign wake      = (mode == MODE_SLEEP) && !sleepReq && atLow;
  assign effShadow = cfgWrEn ? cfgShadow : shadowSel;

  always_comb begin
    ctl.rate    = applyImm ? stagedRate : activeRate;
    ctl.holdLow = (mode == MODE_SLEEP) || (sleepHit && !isFast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode        <= MODE_RUN;
      activeRate  <= CODE_W'(1);
      stagedRate  <= '0;
      stagedValid <= 1'b0;
      stagedImm   <= 1'b0;
      shadowSel   <= 1'b1;
      extCnt      <= '0;
      sleepOk     <= 1'b0;
    end else begin
      sleepOk <= 1'b0;
      case (mode)
        MODE_RUN: begin
          if (sleepHit) begin
            if (isFast) begin
              mode   <= MODE_EXTEND;
              extCnt <= EXT_W'(1);
            end else begin
              mode    <= MODE_SLEEP;
              sleepOk <= 1'b1;
            end
          end else if (applyImm) begin
            activeRate  <= stagedRate;
            stagedValid <= 1'b0;
          end
        end
        MODE_EXTEND: begin
          if (atFall && extCnt == EXT_W'(EXTRA_RISES)) begin
            mode    <= MODE_SLEEP;
            sleepOk <= 1'b1;
          end else if (atLow) begin
            extCnt <= extCnt + 1'b1;
          end
        end
        default: begin
          if (wake) begin
            mode <= MODE_RUN;
            if (stagedValid) begin
              activeRate  <= stagedRate;
              stagedValid <= 1'b0;
            end
          end
        end
      endcase
      if (cfgWrEn) shadowSel <= cfgShadow;
      if (rateWrEn) begin
        stagedRate  <= rateCode;
        stagedValid <= 1'b1;
        stagedImm   <= !effShadow;
      end
    end
  end

  // R9: asleep means the output is low
  assert_sleep_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLEEP) |-> !clkLevel);
  // R3: output off while code 0 is active
  assert_off_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RUN && activeRate == '0) |-> !clkLevel);
  // R7: strobe is a single cycle with the output low
  assert_ok_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    sleepOk |-> (!clkLevel ##1 !sleepOk));
  // R6: a deferred code is never adopted while running
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RUN && stagedValid && !stagedImm) |=> $stable(activeRate));
  // R11: countdown keeps its rate
  assert_extend_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_EXTEND) |=> $stable(activeRate));
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int EXTRA_RISES = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgShadow,
  input  logic              rateWrEn,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              trxOff,
  input  logic              sleepReq,
  output logic              clkOut,
  output logic              sleepOk
);
  dpCtlS ctl;
  logic  atLow, atFall;

  clkout_ctrl #(.EXTRA_RISES(EXTRA_RISES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgShadow(cfgShadow),
    .rateWrEn(rateWrEn), .rateCode(rateCode), .trxOff(trxOff),
    .sleepReq(sleepReq), .atLow(atLow), .atFall(atFall),
    .clkLevel(clkOut), .ctl(ctl), .sleepOk(sleepOk)
  );

  clkout_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .clkLevel(clkOut), .atLow(atLow), .atFall(atFall)
  );

  // R1: quiet outputs right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!clkOut && !sleepOk));
endmodule

// File: tb/clkout_gen_tb.sv
module clkout_gen_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, cfgWrEn = 1'b0, cfgShadow = 1'b0, rateWrEn = 1'b0;
  logic [2:0] rateCode = 3'd0;
  logic trxOff = 1'b0, sleepReq = 1'b0;
  logic clkOut, sleepOk;

  clkout_gen u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgShadow(cfgShadow),
    .rateWrEn(rateWrEn), .rateCode(rateCode), .trxOff(trxOff),
    .sleepReq(sleepReq), .clkOut(clkOut), .sleepOk(sleepOk)
  );

  int nChecks = 0, nFails = 0;
  string curTag = "R1";
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int halfOf(input int c);
    case (c)
      1: return 16; 2: return 8; 3: return 4; 4: return 2; 5: return 1;
      6: return 64; 7: return 256; default: return 1;
    endcase
  endfunction

  // Behavioural reference model: level, cycles left in level, mode 0 run / 1 extend / 2 sleep
  int mLevel, mLeft, mRate, mMode, mExt, mStRate, mStValid, mStImm, mShadow, mOk;
  always @(posedge clk) begin
    if (!rstN) begin
      mLevel = 0; mLeft = 0; mRate = 1; mMode = 0; mExt = 0;
      mStRate = 0; mStValid = 0; mStImm = 0; mShadow = 1; mOk = 0;
    end else begin
      int useRate, hold, sh;
      bit low, fall;
      low = (mLevel == 0 && mLeft == 0);
      fall = (mLevel == 1 && mLeft == 0);
      useRate = mRate; hold = 0; mOk = 0;
      if (mMode == 0) begin
        if (low && sleepReq && trxOff) begin
          if (mRate >= 1 && mRate <= 5) begin mMode = 1; mExt = 1; end
          else begin mMode = 2; mOk = 1; hold = 1; end
        end else if (low && mStValid != 0 && mStImm != 0) begin
          mRate = mStRate; useRate = mStRate; mStValid = 0;
        end
      end else if (mMode == 1) begin
        if (fall && mExt == 35) begin mMode = 2; mOk = 1; end
        else if (low) mExt++;
      end else begin
        hold = 1;
        if (!sleepReq && low) begin
          mMode = 0;
          if (mStValid != 0) begin mRate = mStRate; mStValid = 0; end
        end
      end
      if (fall) begin mLevel = 0; mLeft = halfOf(useRate) - 1; end
      else if (low) begin
        if (hold == 0 && useRate != 0) begin mLevel = 1; mLeft = halfOf(useRate) - 1; end
      end else mLeft--;
      sh = cfgWrEn ? int'(cfgShadow) : mShadow;
      if (cfgWrEn) mShadow = int'(cfgShadow);
      if (rateWrEn) begin mStRate = int'(rateCode); mStValid = 1; mStImm = (sh == 0); end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(clkOut === 1'(mLevel) && sleepOk === 1'(mOk), curTag,
            {30'd0, clkOut, sleepOk}, (mLevel << 1) | mOk);
    end
  end

  task automatic writeRate(input int code, input bit setCfg, input bit sh);
    @(negedge clk);
    cfgWrEn = setCfg; cfgShadow = sh; rateWrEn = 1'b1; rateCode = 3'(code);
    @(negedge clk);
    cfgWrEn = 1'b0; rateWrEn = 1'b0;
  endtask

  // Width of the second complete high level from now
  task automatic measureHigh(input int exp, input string tag);
    int n = 0, guard = 0;
    @(negedge clk);
    repeat (2) begin
      while (clkOut !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
      while (clkOut !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
      n = 0;
      while (clkOut === 1'b1 && guard < 5000) begin @(negedge clk); n++; guard++; end
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic countRises(input int cycles, output int rises);
    bit prev = clkOut;
    rises = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!prev && clkOut) rises++;
      prev = clkOut;
    end
  endtask

  task automatic waitOk(output int rises, output bit seen);
    bit prev = clkOut;
    rises = 0; seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (!prev && clkOut) rises++;
      prev = clkOut;
      if (sleepOk) seen = 1;
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog (all requirements): actual 0 expected 1 (run completed)");
    summary();
  end

  initial begin
    int r;
    bit seen;
    repeat (5) @(negedge clk);
    check(clkOut === 1'b0, "R1 clkOut in reset", int'(clkOut), 0);
    check(sleepOk === 1'b0, "R1 sleepOk in reset", int'(sleepOk), 0);
    rstN = 1'b1;
    measureHigh(16, "R1 default code 1");

    curTag = "R12";
    writeRate(2, 1'b1, 1'b0);
    measureHigh(8, "R12 same-cycle shadow clear");

    curTag = "R2";
    for (int c = 3; c <= 7; c++) begin
      writeRate(c, 1'b0, 1'b0);
      measureHigh(halfOf(c), "R2 level width");
    end
    writeRate(1, 1'b0, 1'b0);
    measureHigh(16, "R2 back to code 1");

    curTag = "R4/R5";
    repeat (5) @(negedge clk);
    writeRate(3, 1'b0, 1'b0);
    measureHigh(4, "R4 immediate switch");

    curTag = "R3";
    writeRate(0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    countRises(600, r);
    check(r == 0, "R3 code 0 rises", r, 0);
    check(clkOut === 1'b0, "R3 code 0 level", int'(clkOut), 0);
    writeRate(3, 1'b0, 1'b0);

    curTag = "R6";
    writeRate(5, 1'b1, 1'b1);
    repeat (50) @(negedge clk);
    measureHigh(4, "R6 deferred code ignored while running");

    curTag = "R10";
    trxOff = 1'b0; sleepReq = 1'b1;
    waitOk(r, seen);
    check(seen == 0, "R10 no strobe without trxOff", int'(seen), 0);
    sleepReq = 1'b0; trxOff = 1'b1;
    measureHigh(4, "R10 clock still running");

    curTag = "R7/R11";
    sleepReq = 1'b1;
    fork
      waitOk(r, seen);
      begin repeat (20) @(negedge clk); writeRate(2, 1'b1, 1'b0); end
    join
    check(seen && r == 35, "R7 extra rises (code 3)", r, 35);
    check(clkOut === 1'b0, "R7 low at strobe", int'(clkOut), 0);
    curTag = "R9";
    countRises(50, r);
    check(r == 0, "R9 held low while asleep", r, 0);
    sleepReq = 1'b0;
    measureHigh(8, "R11 write during countdown applied on wake");

    curTag = "R6/R7";
    writeRate(6, 1'b1, 1'b1);
    sleepReq = 1'b1;
    waitOk(r, seen);
    check(seen && r == 35, "R7 extra rises (code 2)", r, 35);
    sleepReq = 1'b0;
    measureHigh(64, "R6 deferred code applied on wake");

    curTag = "R8";
    sleepReq = 1'b1;
    waitOk(r, seen);
    check(seen && r == 0, "R8 slow rate no extra rises", r, 0);
    sleepReq = 1'b0;
    measureHigh(64, "R9 restart after wake");

    writeRate(0, 1'b1, 1'b0);
    repeat (300) @(negedge clk);
    sleepReq = 1'b1;
    waitOk(r, seen);
    check(seen && r == 0, "R8 off rate immediate strobe", r, 0);
    sleepReq = 1'b0;
    curTag = "R9";
    writeRate(4, 1'b0, 1'b0);
    measureHigh(2, "R9 wake then new code");

    repeat (5) @(negedge clk);
    summary();
  end
endmodule